// File: doc/BRIEF.md
# Multi-Mode Load Address and Fetch Unit

This unit carries out the load-type operations of a small processor core against a synchronous, single-port read memory. A one-cycle start strobe hands it an operation code, the current program counter, a base-register value and the instruction's 16-bit immediate field. It latches these, works out the effective address and issues as many memory reads as the operation needs. It then presents the value bound for the destination register, together with a one-cycle done strobe.

Six operations share one state machine. Two of them only form a value and touch no memory: the address-forming operation and the upper-immediate operation. Three need a single read: PC-relative, base-plus-short-offset and base-plus-wide-displacement. The indirect operation reads a pointer word and then reads again at that pointer. The register file, the decoder and condition flags are left to the surrounding core. While an operation is in flight the unit reports itself busy and takes no notice of further start strobes.

Top module: `load_fetch_unit`

## Requirements
- R1: While reset (rstN low) is held, busy, done and memRd are all 0.
- R2: Operation code 0 (address form) returns pc plus the sign-extended low 9 bits of offset. It issues no read, and done is high in the first cycle after the start edge.
- R3: Operation code 1 (PC-relative load) issues exactly one read at pc plus the sign-extended low 9 bits of offset. It returns the word read, with done high in the third cycle after the start edge.
- R4: Operation code 2 (indirect load) first reads at pc plus the sign-extended low 9 bits of offset. It then reads at the word returned and gives back the second word, with done high in the fifth cycle after the start edge.
- R5: Operation code 3 (base-relative load) issues exactly one read at baseVal plus the sign-extended low 6 bits of offset. It returns the word read three cycles after the start edge.
- R6: Operation code 4 (wide-displacement load) issues exactly one read at baseVal plus all 16 bits of offset, sign-extended. It returns the word read three cycles after the start edge.
- R7: Operation code 5 (upper immediate) returns offset shifted left by 16 with zeros below. It issues no read, and done is high in the first cycle after the start edge.
- R8: memRd is high for one cycle per access and never two cycles in a row. The unit takes memRdata in the cycle after the one in which memRd was high.
- R9: done lasts exactly one cycle. busy is high from the cycle after the start edge through the done cycle and low in the cycle after it.
- R10: A start raised while busy is high, including during the done cycle, has no effect. The operation in flight keeps its addresses, result and timing, and the unit is idle in the cycle after done.
- R11: Operation codes 6 and 7 are ignored. busy, done and memRd all stay 0 after such a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (sampled only when idle) |
| mode | input | 3 | Operation code 0..5 |
| pc | input | DW | Program counter of the instruction |
| baseVal | input | DW | Base register value |
| offset | input | 16 | Immediate field of the instruction |
| memAddr | output | DW | Read address to memory |
| memRd | output | 1 | Read request, one cycle per access |
| memRdata | input | DW | Read data, valid one cycle after the request |
| done | output | 1 | One-cycle completion strobe |
| result | output | DW | Destination value, valid while done is high |
| busy | output | 1 | Operation in flight |

## Verification
A new start can arrive in the same cycle as any step of an operation already running, including its read requests and its done strobe. The bench provokes this on part of the randomly chosen operations by holding start high with fresh random operands from the cycle after the start edge until done. The operation is judged correct only if its read address sequence, result and latency match the undisturbed expectation. busy and memRd must also be low in the cycle after done, which shows that neither the mid-flight start nor the start held during done was captured.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

  typedef enum logic [2:0] {
    OP_ADDR  = 3'd0,
    OP_PCREL = 3'd1,
    OP_INDIR = 3'd2,
    OP_BREL  = 3'd3,
    OP_WIDE  = 3'd4,
    OP_UPPER = 3'd5
  } opKind_t;

  localparam logic [2:0] OP_LAST = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR1 = 3'd1,
    ST_WAIT1 = 3'd2,
    ST_ADDR2 = 3'd3,
    ST_WAIT2 = 3'd4,
    ST_DONE  = 3'd5
  } fsmState_t;

  typedef struct packed {
    logic capture;   // latch operands from the ports
    logic grab;      // latch memory read data
    logic second;    // address memory with the latched pointer word
    logic outAddr;   // result is the effective address
    logic outImm;    // result is the shifted immediate
  } dpStrobe_t;

endpackage

// File: rtl/lfu_control.sv
module lfu_control
  import lfu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] mode,
  output dpStrobe_t  ctl,
  output logic       memRd,
  output logic       done,
  output logic       busy
);

  fsmState_t state, stateNext;
  logic      indirQ;
  logic      addrOnlyQ;
  logic      immOnlyQ;
  logic      accept;

  assign accept = (state == ST_IDLE) && start && (mode <= OP_LAST);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (mode == OP_ADDR || mode == OP_UPPER) stateNext = ST_DONE;
          else                                     stateNext = ST_ADDR1;
        end
      end
      ST_ADDR1: stateNext = ST_WAIT1;
      ST_WAIT1: stateNext = indirQ ? ST_ADDR2 : ST_DONE;
      ST_ADDR2: stateNext = ST_WAIT2;
      ST_WAIT2: stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      indirQ    <= 1'b0;
      addrOnlyQ <= 1'b0;
      immOnlyQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        indirQ    <= (mode == OP_INDIR);
        addrOnlyQ <= (mode == OP_ADDR);
        immOnlyQ  <= (mode == OP_UPPER);
      end
    end
  end

  always_comb begin
    ctl.capture = accept;
    ctl.grab    = (state == ST_WAIT1) || (state == ST_WAIT2);
    ctl.second  = (state == ST_ADDR2) || (state == ST_WAIT2);
    ctl.outAddr = addrOnlyQ;
    ctl.outImm  = immOnlyQ;
  end

  assign memRd = (state == ST_ADDR1) || (state == ST_ADDR2);
  assign done  = (state == ST_DONE);
  assign busy  = (state != ST_IDLE);

  assert_read_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd);

  assert_wait_after_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.grab |-> $past(memRd));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_busy_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  assert_no_read_direct_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && (addrOnlyQ || immOnlyQ)) |-> $past(state == ST_IDLE));

  assert_second_read_only_indirect_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR2) |-> indirQ);

endmodule

// File: rtl/lfu_datapath.sv
module lfu_datapath
  import lfu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     ctl,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] baseVal,
  input  logic [15:0]   offset,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] result
);

  localparam int SHORT_W = 6;
  localparam int MID_W   = 9;
  localparam int WIDE_W  = 16;

  logic [2:0]    modeQ;
  logic [DW-1:0] pcQ, baseQ, wordQ;
  logic [15:0]   offQ;
  logic [DW-1:0] extShort, extMid, extWide, effAddr, immVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      pcQ   <= '0;
      baseQ <= '0;
      offQ  <= '0;
      wordQ <= '0;
    end else begin
      if (ctl.capture) begin
        modeQ <= mode;
        pcQ   <= pc;
        baseQ <= baseVal;
        offQ  <= offset;
      end
      if (ctl.grab) wordQ <= memRdata;
    end
  end

  assign extShort = {{(DW-SHORT_W){offQ[SHORT_W-1]}}, offQ[SHORT_W-1:0]};
  assign extMid   = {{(DW-MID_W){offQ[MID_W-1]}}, offQ[MID_W-1:0]};
  assign extWide  = {{(DW-WIDE_W){offQ[WIDE_W-1]}}, offQ};

  always_comb begin
    unique case (modeQ)
      OP_BREL: effAddr = baseQ + extShort;
      OP_WIDE: effAddr = baseQ + extWide;
      default: effAddr = pcQ + extMid;
    endcase
  end

  always_comb begin
    immVal = '0;
    immVal[WIDE_W +: WIDE_W] = offQ;
  end

  assign memAddr = ctl.second ? wordQ : effAddr;

  always_comb begin
    if (ctl.outAddr)     result = effAddr;
    else if (ctl.outImm) result = immVal;
    else                 result = wordQ;
  end

  assert_pointer_chase_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.second && !ctl.grab) |-> (memAddr == $past(memRdata)));

  assert_operands_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.capture && !$isunknown(offQ)) |=> $stable(offQ) && $stable(pcQ) && $stable(baseQ));

endmodule

// File: rtl/load_fetch_unit.sv
module load_fetch_unit
  import lfu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] baseVal,
  input  logic [15:0]   offset,
  output logic [DW-1:0] memAddr,
  output logic          memRd,
  input  logic [DW-1:0] memRdata,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          busy
);

  dpStrobe_t ctl;

  lfu_control u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .mode  (mode),
    .ctl   (ctl),
    .memRd (memRd),
    .done  (done),
    .busy  (busy)
  );

  lfu_datapath #(.DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .mode     (mode),
    .pc       (pc),
    .baseVal  (baseVal),
    .offset   (offset),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .result   (result)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRd && !done));

endmodule

// File: tb/sim_load_fetch_unit.sv
`timescale 1ns/1ps
module sim_load_fetch_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] pc = '0, baseVal = '0;
  logic [15:0] offset = '0;
  logic [31:0] memAddr, memRdata = '0, result;
  logic        memRd, done, busy;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  load_fetch_unit #(.DW(32)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .pc(pc),
    .baseVal(baseVal), .offset(offset), .memAddr(memAddr), .memRd(memRd),
    .memRdata(memRdata), .done(done), .result(result), .busy(busy)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h1357_2468;
  endfunction

  always @(posedge clk) if (memRd) memRdata <= memf(memAddr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] m, input logic [31:0] p, input logic [31:0] b,
                       input logic [15:0] o, input bit inject);
    logic [31:0] ea, a1, expRes;
    logic [31:0] expAddr[2];
    logic [31:0] seen[4];
    int nExp, n, lat, cyc;
    string req;
    a1 = '0;
    nExp = 1;
    lat = 3;
    case (m)
      3'd0: begin ea = p + {{23{o[8]}}, o[8:0]}; expRes = ea; nExp = 0; lat = 1; req = "R2"; end
      3'd1: begin ea = p + {{23{o[8]}}, o[8:0]}; expRes = memf(ea); req = "R3"; end
      3'd2: begin ea = p + {{23{o[8]}}, o[8:0]}; a1 = memf(ea); expRes = memf(a1);
                  nExp = 2; lat = 5; req = "R4"; end
      3'd3: begin ea = b + {{26{o[5]}}, o[5:0]}; expRes = memf(ea); req = "R5"; end
      3'd4: begin ea = b + {{16{o[15]}}, o}; expRes = memf(ea); req = "R6"; end
      default: begin ea = '0; expRes = {o, 16'h0000}; nExp = 0; lat = 1; req = "R7"; end
    endcase
    expAddr[0] = ea;
    expAddr[1] = a1;
    @(negedge clk);
    start = 1'b1; mode = m; pc = p; baseVal = b; offset = o;
    @(negedge clk);
    if (inject) begin
      mode = 3'($urandom % 6); pc = $urandom; baseVal = $urandom; offset = 16'($urandom);
    end else start = 1'b0;
    n = 0;
    cyc = 1;
    forever begin
      if (memRd) begin
        if (n < 4) seen[n] = memAddr;
        n++;
      end
      if (done) break;
      if (!busy) chk(1'b0, "R9 busy during op", 32'(busy), 32'd1);
      if (cyc > 12) break;
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, {req, " done seen"}, 32'(done), 32'd1);
    chk(result == expRes, {req, " result"}, result, expRes);
    chk(cyc == lat, {req, " latency"}, 32'(cyc), 32'(lat));
    chk(n == nExp, {req, " read count"}, 32'(n), 32'(nExp));
    for (int i = 0; i < nExp && i < n; i++)
      chk(seen[i] == expAddr[i], {req, " read address"}, seen[i], expAddr[i]);
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !memRd, inject ? "R10 idle after done" : "R9 idle after done",
        {29'd0, busy, done, memRd}, 32'd0);
  endtask

  task automatic badOp(input logic [2:0] m);
    @(negedge clk);
    start = 1'b1; mode = m; pc = $urandom; baseVal = $urandom; offset = 16'($urandom);
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done && !memRd, "R11 unused code ignored", {29'd0, busy, done, memRd}, 32'd0);
    @(negedge clk);
    chk(!busy && !done && !memRd, "R11 still idle", {29'd0, busy, done, memRd}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memRd, "R1 reset state", {29'd0, busy, done, memRd}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // directed corners
    runOp(3'd0, 32'h0000_1000, 32'h0, 16'h0100, 1'b0);   // R2 most negative 9-bit
    runOp(3'd0, 32'hFFFF_FFFF, 32'h0, 16'hFE01, 1'b0);   // R2 wrap, upper bits ignored
    runOp(3'd1, 32'h0000_2000, 32'h0, 16'h00FF, 1'b0);   // R3 largest positive
    runOp(3'd2, 32'h0000_3000, 32'h0, 16'h01F0, 1'b0);   // R4 indirect
    runOp(3'd3, 32'h0, 32'h0000_4000, 16'hFFE0, 1'b0);   // R5 most negative 6-bit
    runOp(3'd3, 32'h0, 32'h0000_4000, 16'h001F, 1'b0);   // R5 largest positive
    runOp(3'd4, 32'h0, 32'h0001_0000, 16'h8000, 1'b0);   // R6 most negative
    runOp(3'd4, 32'h0, 32'h0001_0000, 16'h7FFF, 1'b0);   // R6 largest positive
    runOp(3'd5, 32'h0, 32'h0, 16'hFFFF, 1'b0);           // R7
    runOp(3'd2, 32'h0000_5000, 32'h0, 16'h0010, 1'b1);   // R10 on longest op
    runOp(3'd0, 32'h0000_6000, 32'h0, 16'h0001, 1'b1);   // R10 start held in done cycle
    badOp(3'd6);                                         // R11
    badOp(3'd7);                                         // R11

    for (int k = 0; k < 400; k++)
      runOp(3'($urandom % 6), $urandom, $urandom, 16'($urandom), ($urandom % 3) == 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule